// File: doc/BRIEF.md
# Host link signal frame decoder

This block sits on the receive side of a 32-bit packet link from a host. It looks at every packet and sorts it into one of three kinds: a control signal, a kernel request that spans several packets, or a payload word. A signal packet begins with an all-ones leading byte followed by a one-hot type byte. A request opens with the request type and then carries the region bitmap in the packets that follow. A packet whose leading byte is the end marker closes it. Anything else, including an all-ones packet whose type byte is not one-hot, is handed on unchanged as payload for whichever phase the consumer is in.

A request is accepted only when exactly the expected number of body packets arrive before the end marker. The assembled region bitmap is then presented with a one-cycle strobe. Too few or too many body packets drop the request and raise a one-cycle error strobe instead. The same block also builds the outgoing single-packet signals toward the host (acknowledges, completions, flushes) from a type code, behind a valid/ready handshake with one register stage.

Top module: `hl_sig_frame_codec`

## Requirements
- R1: After reset, data_valid, sig_valid, req_valid, req_err and tx_valid are low, and ack_ready is high.
- R2: Outside a request, a packet with bits [31:24] not equal to 8'hFF (the value 8'hFE included) appears unchanged on data_word with data_valid high for exactly the cycle after it was taken.
- R3: Outside a request, a packet with bits [31:24] = 8'hFF and bits [23:16] one of 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80 gives sig_valid with sig_code equal to bits [23:16] in the cycle after it was taken, and no data_valid.
- R4: Outside a request, a packet with bits [31:24] = 8'hFF and bits [23:16] having zero or more than one bit set is treated as payload exactly as in R2.
- R5: A packet with bits [31:24] = 8'hFF and bits [23:16] = 8'h01 opens a request. Every following packet whose bits [31:24] are not 8'hFE is a body packet: body packet k (from 0) fills req_map[32k+31:32k], and no body packet raises data_valid or sig_valid.
- R6: A packet with bits [31:24] = 8'hFE after exactly REGIONS/32 body packets (2 by default) gives req_valid, with req_map holding the bitmap, in the cycle after the end packet. Decoding then returns to the state outside a request.
- R7: An end packet after fewer or more than REGIONS/32 body packets gives req_err instead of req_valid in the cycle after it. Decoding then returns to the state outside a request.
- R8: Cycles with rx_valid low raise no strobe and do not change the body packet count of an open request.
- R9: A code taken with ack_valid and ack_ready high is sent in the next cycle as tx_data = {8'hFF, code, 16'h0000} with tx_valid high.
- R10: While tx_valid is high and tx_ready low, tx_data holds its value and ack_ready is low. When tx_ready is high, ack_ready is high.
- R11: At most one of data_valid, sig_valid, req_valid and req_err is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Incoming packet present this cycle |
| rx_data | input | 32 | Incoming packet |
| data_valid | output | 1 | Payload word strobe |
| data_word | output | 32 | Payload word |
| sig_valid | output | 1 | Control signal strobe |
| sig_code | output | 8 | One-hot type of the received signal |
| req_valid | output | 1 | Complete request strobe |
| req_map | output | REGIONS | Region bitmap of the request |
| req_err | output | 1 | Request dropped for a wrong body length |
| ack_valid | input | 1 | Outgoing signal code offered |
| ack_code | input | 8 | One-hot type of the outgoing signal |
| ack_ready | output | 1 | Outgoing code is taken this cycle |
| tx_valid | output | 1 | Outgoing packet present |
| tx_data | output | 32 | Outgoing packet |
| tx_ready | input | 1 | Link takes the outgoing packet |

## Verification
The assertions assume that the host side offers only one-hot type codes on ack_code and that the link does not pull tx_valid's packet away from the encoder except through tx_ready. The stimulus keeps to this by sending only the eight defined codes on the outgoing path. The receive path has no such limit: the sweeps cover every leading byte and every type byte, and requests use zero to four body packets, gaps in the packet stream and body packets that themselves look like signals.

// File: rtl/hl_link_pkg.sv
package hl_link_pkg;
    localparam logic [7:0] LEAD_SIG = 8'hFF;
    localparam logic [7:0] LEAD_END = 8'hFE;
    localparam logic [7:0] HDR_REQ  = 8'h01;
    localparam int         PKT_W    = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BODY = 1'b1
    } dec_state_e;
endpackage

// File: rtl/hl_frame_classify.sv
module hl_frame_classify
    import hl_link_pkg::*;
(
    input  logic [7:0] lead_byte,
    input  logic [7:0] type_byte,
    output logic       is_sig,
    output logic       is_req,
    output logic       is_end
);
    logic hdr_onehot;

    always_comb begin
        hdr_onehot = ($countones(type_byte) == 1);
        is_sig     = (lead_byte == LEAD_SIG) && hdr_onehot;
        is_req     = is_sig && (type_byte == HDR_REQ);
        is_end     = (lead_byte == LEAD_END);
    end
endmodule

// File: rtl/hl_req_collect.sv
module hl_req_collect
    import hl_link_pkg::*;
#(
    parameter int REGIONS = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [PKT_W-1:0]   rx_data,
    input  logic               is_sig,
    input  logic               is_req,
    input  logic               is_end,
    output logic               data_valid,
    output logic [PKT_W-1:0]   data_word,
    output logic               sig_valid,
    output logic [7:0]         sig_code,
    output logic               req_valid,
    output logic [REGIONS-1:0] req_map,
    output logic               req_err
);
    localparam int BODY_WORDS = REGIONS / PKT_W;
    localparam int CNT_W      = $clog2(BODY_WORDS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BODY_WORDS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(BODY_WORDS + 1);

    typedef struct packed {
        dec_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [REGIONS-1:0] map;
        logic               data_valid;
        logic [PKT_W-1:0]   data_word;
        logic               sig_valid;
        logic [7:0]         sig_code;
        logic               req_valid;
        logic               req_err;
    } col_reg_t;

    col_reg_t col_d, col_q;

    always_comb begin
        col_d            = col_q;
        col_d.data_valid = 1'b0;
        col_d.sig_valid  = 1'b0;
        col_d.req_valid  = 1'b0;
        col_d.req_err    = 1'b0;
        if (rx_valid) begin
            unique case (col_q.st)
                ST_IDLE: begin
                    if (is_req) begin
                        col_d.st  = ST_BODY;
                        col_d.cnt = '0;
                        col_d.map = '0;
                    end else if (is_sig) begin
                        col_d.sig_valid = 1'b1;
                        col_d.sig_code  = rx_data[23:16];
                    end else begin
                        col_d.data_valid = 1'b1;
                        col_d.data_word  = rx_data;
                    end
                end
                ST_BODY: begin
                    if (is_end) begin
                        col_d.st = ST_IDLE;
                        if (col_q.cnt == CNT_FULL) begin
                            col_d.req_valid = 1'b1;
                        end else begin
                            col_d.req_err = 1'b1;
                        end
                    end else begin
                        for (int k = 0; k < BODY_WORDS; k++) begin
                            if (col_q.cnt == CNT_W'(k)) begin
                                col_d.map[PKT_W*k +: PKT_W] = rx_data;
                            end
                        end
                        if (col_q.cnt != CNT_OVER) begin
                            col_d.cnt = col_q.cnt + 1'b1;
                        end
                    end
                end
                default: col_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '{st: ST_IDLE, default: '0};
        end else begin
            col_q <= col_d;
        end
    end

    assign data_valid = col_q.data_valid;
    assign data_word  = col_q.data_word;
    assign sig_valid  = col_q.sig_valid;
    assign sig_code   = col_q.sig_code;
    assign req_valid  = col_q.req_valid;
    assign req_map    = col_q.map;
    assign req_err    = col_q.req_err;

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_valid, sig_valid, req_valid, req_err}));

    // R3
    sig_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |-> ($onehot(sig_code) && sig_code != HDR_REQ));

    // R8
    strobe_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !(data_valid || sig_valid || req_valid || req_err));

    // R5
    body_no_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q.st == ST_BODY && rx_valid && !is_end) |=> !(data_valid || sig_valid));

    // R6
    end_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || req_err) |-> col_q.st == ST_IDLE);
endmodule

// File: rtl/hl_sig_encode.sv
module hl_sig_encode
    import hl_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_valid,
    input  logic [7:0]       ack_code,
    output logic             ack_ready,
    output logic             tx_valid,
    output logic [PKT_W-1:0] tx_data,
    input  logic             tx_ready
);
    typedef struct packed {
        logic             vld;
        logic [PKT_W-1:0] word;
    } enc_reg_t;

    enc_reg_t enc_d, enc_q;

    always_comb begin
        ack_ready = !enc_q.vld || tx_ready;
        enc_d     = enc_q;
        if (tx_ready) begin
            enc_d.vld = 1'b0;
        end
        if (ack_valid && ack_ready) begin
            enc_d.vld  = 1'b1;
            enc_d.word = {LEAD_SIG, ack_code, 16'h0000};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_q <= '0;
        end else begin
            enc_q <= enc_d;
        end
    end

    assign tx_valid = enc_q.vld;
    assign tx_data  = enc_q.word;

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R9
    tx_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_data[31:24] == LEAD_SIG && tx_data[15:0] == 16'h0000));

    // R9
    tx_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_ready) |=> (tx_valid && tx_data[23:16] == $past(ack_code)));
endmodule

// File: rtl/hl_sig_frame_codec.sv
module hl_sig_frame_codec
    import hl_link_pkg::*;
#(
    parameter int REGIONS = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [31:0]        rx_data,
    output logic               data_valid,
    output logic [31:0]        data_word,
    output logic               sig_valid,
    output logic [7:0]         sig_code,
    output logic               req_valid,
    output logic [REGIONS-1:0] req_map,
    output logic               req_err,
    input  logic               ack_valid,
    input  logic [7:0]         ack_code,
    output logic               ack_ready,
    output logic               tx_valid,
    output logic [31:0]        tx_data,
    input  logic               tx_ready
);
    logic cls_sig, cls_req, cls_end;

    hl_frame_classify cls_i (
        .lead_byte (rx_data[31:24]),
        .type_byte (rx_data[23:16]),
        .is_sig    (cls_sig),
        .is_req    (cls_req),
        .is_end    (cls_end)
    );

    hl_req_collect #(.REGIONS(REGIONS)) col_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .is_sig     (cls_sig),
        .is_req     (cls_req),
        .is_end     (cls_end),
        .data_valid (data_valid),
        .data_word  (data_word),
        .sig_valid  (sig_valid),
        .sig_code   (sig_code),
        .req_valid  (req_valid),
        .req_map    (req_map),
        .req_err    (req_err)
    );

    hl_sig_encode enc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_valid (ack_valid),
        .ack_code  (ack_code),
        .ack_ready (ack_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !(data_valid || sig_valid || req_valid || req_err || tx_valid));
endmodule

// File: tb/hl_sig_frame_codec_tb.sv
module hl_sig_frame_codec_tb_top;
    localparam int REGIONS = 64;
    localparam int BODY    = REGIONS / 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rx_valid = 1'b0;
    logic [31:0]        rx_data = '0;
    logic               data_valid, sig_valid, req_valid, req_err;
    logic [31:0]        data_word;
    logic [7:0]         sig_code;
    logic [REGIONS-1:0] req_map;
    logic               ack_valid = 1'b0;
    logic [7:0]         ack_code = '0;
    logic               ack_ready, tx_valid, tx_ready = 1'b1;
    logic [31:0]        tx_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hl_sig_frame_codec #(.REGIONS(REGIONS)) dut_i (
        .clk, .rst_n, .rx_valid, .rx_data,
        .data_valid, .data_word, .sig_valid, .sig_code,
        .req_valid, .req_map, .req_err,
        .ack_valid, .ack_code, .ack_ready,
        .tx_valid, .tx_data, .tx_ready
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 nothing, 1 data, 2 signal, 3 request, 4 error
    task automatic expect_out(input int kind, input string req, input logic [63:0] val);
        logic [3:0] want;
        want = 4'b0000;
        if (kind == 1) want = 4'b1000;
        if (kind == 2) want = 4'b0100;
        if (kind == 3) want = 4'b0010;
        if (kind == 4) want = 4'b0001;
        chk({data_valid, sig_valid, req_valid, req_err} == want, req,
            64'({data_valid, sig_valid, req_valid, req_err}), 64'(want));
        if (kind == 1) chk(data_word == val[31:0], req, 64'(data_word), val);
        if (kind == 2) chk(sig_code == val[7:0], req, 64'(sig_code), val);
        if (kind == 3) chk(req_map == val, req, req_map, val);
    endtask

    task automatic send(input logic [31:0] pkt);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = pkt;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic run_request(input int nbody, input logic [31:0] w0, input logic [31:0] w1);
        logic [63:0] want;
        send(32'hFF01_0000);
        expect_out(0, "R5 request open", 0);
        for (int b = 0; b < nbody; b++) begin
            send(b == 0 ? w0 : (b == 1 ? w1 : 32'hFF40_0000 + b));
            expect_out(0, "R5 body not forwarded", 0);
            if (b == 0) begin
                @(negedge clk);
                expect_out(0, "R8 gap in body", 0);
            end
        end
        send(32'hFE00_0000);
        want = {w1, w0};
        if (nbody == BODY) expect_out(3, "R6 request complete", want);
        else               expect_out(4, "R7 wrong body length", 0);
        send(32'h1234_5678);
        expect_out(1, "R6 back to idle", 64'h1234_5678);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({data_valid, sig_valid, req_valid, req_err, tx_valid} == 5'b0, "R1 strobes",
            64'({data_valid, sig_valid, req_valid, req_err, tx_valid}), 0);
        rst_n = 1'b1;
        chk(ack_ready == 1'b1, "R1 ack_ready", 64'(ack_ready), 1);

        // R2: every leading byte except all-ones is payload
        for (int lb = 0; lb < 256; lb++) begin
            if (lb != 255) begin
                send({8'(lb), 8'(lb ^ 8'h5A), 16'(lb * 37)});
                expect_out(1, "R2 payload", 64'({8'(lb), 8'(lb ^ 8'h5A), 16'(lb * 37)}));
            end
        end

        // R3 / R4: every type byte under an all-ones lead
        for (int h = 0; h < 256; h++) begin
            if (h != 1) begin
                send({8'hFF, 8'(h), 16'hBEEF});
                if ($countones(8'(h)) == 1) expect_out(2, "R3 signal", 64'(h));
                else expect_out(1, "R4 bad header as payload", 64'({8'hFF, 8'(h), 16'hBEEF}));
            end
        end

        // R5..R8: body lengths 0..4
        for (int n = 0; n <= 4; n++) begin
            run_request(n, 32'hA5A5_0000 + n, 32'hFF20_0000 + n);
        end
        run_request(BODY, 32'h0000_0001, 32'h8000_0000);

        // R9 / R10: outgoing signals
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            tx_ready  = 1'b0;
            ack_valid = 1'b1;
            ack_code  = 8'(1 << c);
            chk(ack_ready == 1'b1, "R10 ready when empty", 64'(ack_ready), 1);
            @(negedge clk);
            ack_valid = 1'b0;
            chk(tx_valid && tx_data == {8'hFF, 8'(1 << c), 16'h0000}, "R9 encoded packet",
                64'({tx_valid, tx_data}), 64'({1'b1, 8'hFF, 8'(1 << c), 16'h0000}));
            chk(ack_ready == 1'b0, "R10 stalled", 64'(ack_ready), 0);
            @(negedge clk);
            chk(tx_valid && tx_data == {8'hFF, 8'(1 << c), 16'h0000}, "R10 held",
                64'({tx_valid, tx_data}), 64'({1'b1, 8'hFF, 8'(1 << c), 16'h0000}));
            tx_ready = 1'b1;
            #0;
            chk(ack_ready == 1'b1, "R10 ready on drain", 64'(ack_ready), 1);
            @(negedge clk);
            chk(tx_valid == 1'b0, "R9 drained", 64'(tx_valid), 0);
        end
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule